// File: doc/BRIEF.md
# Prioritised Interrupt Concentrator

This block merges up to 32 peripheral interrupt lines into a single request line for a processor core that accepts only one interrupt. Software programs and inspects it through a small 32-bit register bus. Each access completes in one cycle: writes take effect at the clock edge, and read data is valid in the same cycle the read strobe is high. The block latches every source into a status register and masks it with an enable register. It reports the lowest-numbered source that is both latched and enabled through a vector register. It raises `irq` when at least one such source exists and the master enable is on.

Bring-up happens in two stages. With only the master enable set, the hardware inputs are ignored and software may force status bits by writing to the status register, so the handler path can be tested alone. Setting the hardware-enable bit hands the status register over to the input lines and stops software forcing. That bit cannot be cleared again except by reset. Each source is captured either on a rising edge or by level, chosen per source by a parameter mask.

Top module: `irq_hub`

## Requirements
- R1: After reset, every register reads zero except the vector register, which reads 0xFFFFFFFF, and `irq` is low.
- R2: Register bit positions follow the source index. The control register at 0x1C has bit 0 as the master enable and bit 1 as the hardware enable. `irq` is high exactly when the master enable is 1 and some status bit is set whose enable bit is also set.
- R3: A write of 1 to bit 1 of the control register at 0x1C sets the hardware enable. No later write clears it, while bit 0 still follows each write.
- R4: While the hardware enable is 0, writing 1s to the status register at 0x00 sets those status bits.
- R5: While the hardware enable is 0, the inputs `src_in` never set status bits. Once it is 1, status-register writes set nothing, and only inputs set status bits.
- R6: Writing 1s to the acknowledge register at 0x0C clears those status bits. When a hardware capture and an acknowledge hit the same bit in the same cycle, the capture wins and the bit stays set.
- R7: A write to 0x08 loads the enable register. Writing 1s to 0x10 sets the matching enable bits, and writing 1s to 0x14 clears them. All other enable bits keep their values.
- R8: The pending register at 0x04 reads as status AND enable.
- R9: The vector register at 0x18 reads the index of the lowest-numbered pending source, or 0xFFFFFFFF when none is pending.
- R10: Sources whose bit in EDGE_MASK is 1 (bits 0 to 3 by default) set their status bit only on a 0-to-1 change of the input. Other sources set their status bit on every cycle the input is high, so a level source that is still high is set again right after an acknowledge.
- R11: The acknowledge (0x0C), set-enable (0x10) and clear-enable (0x14) registers read as zero. Writing 0s to the status register clears nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; read data is zero when low |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| src_in | input | NSRC | Peripheral interrupt lines |
| irq | output | 1 | Request to the processor |

## Verification
Two operations can collide in the same cycle: a software acknowledge of a status bit and a fresh hardware capture of that same bit. The bench provokes this by raising an edge-captured input on the same cycle as an acknowledge write that targets it. It then judges the outcome by reading the status register, which must still show the bit set, and by checking that `irq` stays high. A second test acknowledges a level source whose input is still high; the bit must come back at once, while an edge source held high must stay cleared.

// File: rtl/irq_hub.sv
module irq_hub #(
  parameter int          NSRC      = 8,
  parameter logic [31:0] EDGE_MASK = 32'h0000_000F
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [4:0]      bus_addr,
  input  logic            bus_wr,
  input  logic            bus_rd,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  input  logic [NSRC-1:0] src_in,
  output logic            irq
);
  localparam logic [2:0] A_STAT = 3'd0, A_PEND = 3'd1, A_ENAB = 3'd2, A_ACK = 3'd3,
                         A_SETE = 3'd4, A_CLRE = 3'd5, A_VEC  = 3'd6, A_CTRL = 3'd7;
  localparam logic [NSRC-1:0] EDGE = EDGE_MASK[NSRC-1:0];

  logic [NSRC-1:0] stat_q, en_q, src_q;
  logic [1:0]      mer_q;
  logic [31:0]     vec;

  wire [2:0]      widx   = bus_addr[4:2];
  wire [NSRC-1:0] wd     = bus_wdata[NSRC-1:0];
  wire            hw_on  = mer_q[1];
  wire            wr_st  = bus_wr && widx == A_STAT;
  wire            wr_en  = bus_wr && widx == A_ENAB;
  wire            wr_ack = bus_wr && widx == A_ACK;
  wire            wr_se  = bus_wr && widx == A_SETE;
  wire            wr_ce  = bus_wr && widx == A_CLRE;
  wire            wr_mer = bus_wr && widx == A_CTRL;
  wire            unused_ok = &{1'b0, bus_addr[1:0], bus_wdata};

  wire [NSRC-1:0] rise   = src_in & ~src_q;
  wire [NSRC-1:0] hw_set = hw_on ? ((rise & EDGE) | (src_in & ~EDGE)) : '0;
  wire [NSRC-1:0] sw_set = (wr_st && !hw_on) ? wd : '0;
  wire [NSRC-1:0] clr    = wr_ack ? wd : '0;
  wire [NSRC-1:0] pend   = stat_q & en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      en_q   <= '0;
      src_q  <= '0;
      mer_q  <= '0;
    end else begin
      src_q  <= src_in;
      stat_q <= (stat_q & ~clr) | hw_set | sw_set;
      if (wr_en)      en_q <= wd;
      else if (wr_se) en_q <= en_q | wd;
      else if (wr_ce) en_q <= en_q & ~wd;
      if (wr_mer) mer_q <= {mer_q[1] | bus_wdata[1], bus_wdata[0]};
    end
  end

  always_comb begin
    vec = '1;
    for (int i = NSRC - 1; i >= 0; i--)
      if (pend[i]) vec = 32'(i);
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (widx)
        A_STAT:  bus_rdata = 32'(stat_q);
        A_PEND:  bus_rdata = 32'(pend);
        A_ENAB:  bus_rdata = 32'(en_q);
        A_VEC:   bus_rdata = vec;
        A_CTRL:  bus_rdata = 32'(mer_q);
        default: bus_rdata = '0;
      endcase
    end
  end

  assign irq = mer_q[0] & |pend;
endmodule

// File: rtl/irq_hub_chk.sv
module irq_hub_chk #(
  parameter int NSRC = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic [4:0]      bus_addr,
  input logic            bus_wr,
  input logic [31:0]     bus_wdata,
  input logic [1:0]      mer,
  input logic [NSRC-1:0] stat,
  input logic [NSRC-1:0] en
);
  // R3
  hw_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mer[1] |=> mer[1]);

  // R5
  no_early_hw_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mer[1] && !(bus_wr && bus_addr[4:2] == 3'd0)) |=> ((stat & ~$past(stat)) == '0));

  // R6
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mer[1] && bus_wr && bus_addr[4:2] == 3'd3) |=> ((stat & $past(bus_wdata[NSRC-1:0])) == '0));

  // R7
  set_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr[4:2] == 3'd4) |=> ((en & $past(bus_wdata[NSRC-1:0])) == $past(bus_wdata[NSRC-1:0])));

  // R7
  clear_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr[4:2] == 3'd5) |=> ((en & $past(bus_wdata[NSRC-1:0])) == '0));

  // R7
  enable_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && (bus_addr[4:2] == 3'd2 || bus_addr[4:2] == 3'd4 || bus_addr[4:2] == 3'd5)) |=> $stable(en));
endmodule

bind irq_hub irq_hub_chk #(.NSRC(NSRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .mer(mer_q), .stat(stat_q), .en(en_q)
);

// File: tb/irq_hub_test.sv
module irq_hub_test;
  logic        clk = 0, rst_n = 0, bus_wr = 0, bus_rd = 0, irq;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [7:0]  src_in = '0;
  int checks = 0, errors = 0;

  irq_hub #(.NSRC(8), .EDGE_MASK(32'h0F)) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_in(src_in), .irq(irq)
  );

  always #2 clk = ~clk;

  // entry: {is_read, addr, data_or_expected, requirement}
  localparam int NV = 20;
  localparam logic [41:0] VEC [NV] = '{
    {1'b1, 5'h1C, 32'h0,  4'd1},   // R1
    {1'b0, 5'h08, 32'h0F, 4'd7},   // R7
    {1'b0, 5'h00, 32'h05, 4'd4},   // R4
    {1'b1, 5'h00, 32'h05, 4'd4},   // R4
    {1'b1, 5'h04, 32'h05, 4'd8},   // R8
    {1'b1, 5'h18, 32'h0,  4'd9},   // R9
    {1'b0, 5'h14, 32'h01, 4'd7},   // R7
    {1'b1, 5'h08, 32'h0E, 4'd7},   // R7
    {1'b1, 5'h04, 32'h04, 4'd8},   // R8
    {1'b1, 5'h18, 32'h2,  4'd9},   // R9
    {1'b0, 5'h10, 32'h30, 4'd7},   // R7
    {1'b1, 5'h08, 32'h3E, 4'd7},   // R7
    {1'b1, 5'h10, 32'h0,  4'd11},  // R11
    {1'b0, 5'h0C, 32'h04, 4'd6},   // R6
    {1'b1, 5'h00, 32'h01, 4'd6},   // R6
    {1'b1, 5'h18, 32'hFFFF_FFFF, 4'd9}, // R9
    {1'b0, 5'h00, 32'h80, 4'd4},   // R4
    {1'b0, 5'h00, 32'h00, 4'd11},  // R11
    {1'b1, 5'h00, 32'h81, 4'd11},  // R11
    {1'b1, 5'h0C, 32'h0,  4'd11}   // R11
  };

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(posedge clk); #1 bus_wr = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1;
    #1 d = bus_rdata;
    bus_rd = 0;
  endtask

  task automatic rchk(input string tag, input logic [4:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    check(tag, d, exp);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 check("R1 irq at reset", {31'b0, irq}, 0);
    rst_n = 1;
    rchk("R1 status", 5'h00, 0);
    rchk("R1 enable", 5'h08, 0);
    rchk("R1 vector", 5'h18, 32'hFFFF_FFFF);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][41]) rchk($sformatf("R%0d vector row %0d", VEC[i][3:0], i), VEC[i][40:36], VEC[i][35:4]);
      else wr(VEC[i][40:36], VEC[i][35:4]);
    end

    // state: status 0x81, enable 0x3E, control 0
    wr(5'h10, 32'h80);
    #1 check("R2 irq master off", {31'b0, irq}, 0);
    wr(5'h1C, 32'h1);
    #1 check("R2 irq master on", {31'b0, irq}, 1);
    rchk("R9 vector bit7", 5'h18, 7);
    wr(5'h0C, 32'h81);
    #1 check("R2 irq after ack", {31'b0, irq}, 0);

    @(negedge clk) src_in = 8'hFF;
    repeat (3) @(posedge clk);
    rchk("R5 inputs ignored before hw enable", 5'h00, 0);
    @(negedge clk) src_in = 8'h00;

    wr(5'h1C, 32'h3);
    rchk("R3 hw enable set", 5'h1C, 3);
    wr(5'h1C, 32'h0);
    rchk("R3 hw enable sticky", 5'h1C, 2);
    wr(5'h1C, 32'h1);
    rchk("R3 master back on", 5'h1C, 3);
    wr(5'h00, 32'h01);
    rchk("R5 status write ignored after hw enable", 5'h00, 0);

    @(negedge clk) src_in = 8'h02;
    @(posedge clk);
    rchk("R5 edge input captured", 5'h00, 32'h02);
    wr(5'h0C, 32'h02);
    rchk("R10 edge held high stays clear", 5'h00, 0);
    @(negedge clk) src_in = 8'h22;
    @(posedge clk);
    wr(5'h0C, 32'h20);
    rchk("R10 level re-sets after ack", 5'h00, 32'h20);
    @(negedge clk) src_in = 8'h00;
    wr(5'h0C, 32'h20);
    rchk("R10 level cleared after drop", 5'h00, 0);

    @(negedge clk);
    bus_addr = 5'h0C; bus_wdata = 32'h08; bus_wr = 1; src_in = 8'h08;
    @(posedge clk); #1 bus_wr = 0;
    rchk("R6 capture beats ack", 5'h00, 32'h08);
    #1 check("R2 irq with pending bit3", {31'b0, irq}, 1);
    @(negedge clk) src_in = 8'h00;
    wr(5'h0C, 32'h08);

    @(negedge clk) src_in = 8'h90;
    @(posedge clk);
    rchk("R9 lowest pending wins", 5'h18, 4);
    @(negedge clk) src_in = 8'h80;
    wr(5'h0C, 32'h10);
    rchk("R9 next pending", 5'h18, 7);
    rchk("R8 pending view", 5'h04, 32'h80);

    @(negedge clk) rst_n = 0;
    #1 check("R1 irq after reset", {31'b0, irq}, 0);
    @(negedge clk) rst_n = 1; src_in = 8'h00;
    rchk("R1 control after reset", 5'h1C, 0);
    rchk("R1 vector after reset", 5'h18, 32'hFFFF_FFFF);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule